// File: doc/BRIEF.md
# Bidirectional Open-Drain Repeater Channel

This block is the decision logic for one wire (data or clock) of a two-sided open-drain bus repeater. Each side, A and B, presents a sampled line level (1 = high) and receives a pull-low enable. When an external device pulls one side low, the block records that side as the leading side and pulls the other side low. It keeps pulling until the leading side's driver lets go. Its own forced low on the following side is never mistaken for an external driver, so the two sides cannot hold each other low.

After a release, once both sides read high again, the block raises a boost pulse on each side for a fixed number of clock cycles. This pulse commands a rise-time accelerator. Boost pulses are gated by an accelerator-enable input and by the connect input from the connection controller. Repeating continues when only the accelerator is turned off. Disconnecting removes both pull-low enables at once.

A full two-wire repeater uses two independent instances. Their directions need not agree. The line levels are assumed to be already synchronised to `clk`.

Top module: `odrep_channel`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after reset, all four outputs are 0.
- R2: From idle with `connect_i`=1, a low on `a_level_i` sampled at an edge sets `b_pull_o` to 1 after that edge. It stays 1 for as long as `a_level_i` remains low and `connect_i` stays 1.
- R3: Side B behaves in the mirror image of side A. A low on `b_level_i` from idle sets `a_pull_o`, which is held until `b_level_i` returns high.
- R4: While a side is leading, the low on the following side is ignored. `a_pull_o` and `b_pull_o` are never 1 together.
- R5: When the leading side is sampled high, both pull outputs are 0 after that edge. The block returns to idle only on an edge where both levels are high.
- R6: If both levels are sampled low on the same edge while idle, side A leads: `b_pull_o`=1 and `a_pull_o`=0.
- R7: On the first edge where both levels are high after an edge where they were not, and with `connect_i`=1 and `accel_en_i`=1, `a_boost_o` and `b_boost_o` both rise after that edge. They stay high for exactly `ACCEL_CYCLES` cycles. A new trigger reloads the count.
- R8: No boost pulse starts on a falling edge or while either level is low.
- R9: With `accel_en_i`=0, both boost outputs are 0 from the next edge on, and no pulse starts. Repeating of lows (R2, R3) is unaffected.
- R10: With `connect_i`=0, both pull outputs are 0 in the same cycle. The boost outputs are 0 from the next edge. The direction returns to idle, so after reconnection the first low seen takes the lead afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| connect_i | input | 1 | 1 = channel connected by the connection controller |
| accel_en_i | input | 1 | 1 = rise-accelerator pulses allowed |
| a_level_i | input | 1 | Sampled level of side A (1 = high) |
| b_level_i | input | 1 | Sampled level of side B (1 = high) |
| a_pull_o | output | 1 | Pull side A low |
| b_pull_o | output | 1 | Pull side B low |
| a_boost_o | output | 1 | Rise-accelerator command for side A |
| b_boost_o | output | 1 | Rise-accelerator command for side B |

## Verification
The following are checked on every cycle:
- The two pull outputs are never active together.
- Disconnection drops both pulls at once.
- Boost is gated by enable and connect.
- Both boost outputs stay identical.
- A boost starts only after an edge where both levels were high.
- A pull begins only after its opposite level was seen low, and is held or released according to the leading level.

Three things are shown only by the bench's scenarios: the exact pulse length, the tie going to side A, and a fresh direction choice after reconnection. These run against a cycle-level model inside a closed wired-AND loop that feeds the pull outputs back onto the levels.

// File: rtl/odrep_pkg.sv
// Shared types for the open-drain repeater channel.
// Assumes: nothing beyond the 2-bit direction encoding below.
package odrep_pkg;

    // Which side currently leads the wire.
    typedef enum logic [1:0] {
        DIR_IDLE    = 2'd0,  // nobody leads, no pull applied
        DIR_A_LEADS = 2'd1,  // A driven low externally, B pulled low
        DIR_B_LEADS = 2'd2,  // B driven low externally, A pulled low
        DIR_SETTLE  = 2'd3   // leader released, waiting for both sides high
    } dir_e;

endpackage

// File: rtl/odrep_dir_ctrl.sv
// Direction latch of the repeater channel.
// Picks the side first seen low as leader (A wins ties), holds it while
// the leader stays low, ignores the follower's level while leading, then
// waits in a settle state until both sides read high before going idle.
// Assumes levels are synchronous to clk; connect_i low forces idle.
module odrep_dir_ctrl
    import odrep_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic connect_i,
    input  logic a_high_i,
    input  logic b_high_i,
    output dir_e dir_o
);

    dir_e dir_q;
    dir_e dir_d;

    // Next-direction decision.
    always_comb begin
        dir_d = dir_q;
        if (!connect_i) begin
            dir_d = DIR_IDLE;
        end else begin
            case (dir_q)
                DIR_IDLE: begin
                    if (!a_high_i)      dir_d = DIR_A_LEADS;
                    else if (!b_high_i) dir_d = DIR_B_LEADS;
                end
                DIR_A_LEADS: if (a_high_i) dir_d = DIR_SETTLE;
                DIR_B_LEADS: if (b_high_i) dir_d = DIR_SETTLE;
                DIR_SETTLE:  if (a_high_i && b_high_i) dir_d = DIR_IDLE;
                default:     dir_d = DIR_IDLE;
            endcase
        end
    end

    // Direction register.
    always_ff @(posedge clk) begin
        if (!rst_n) dir_q <= DIR_IDLE;
        else        dir_q <= dir_d;
    end

    assign dir_o = dir_q;

endmodule

// File: rtl/odrep_release_det.sv
// Release detector: flags the first cycle in which both sides read high
// after a cycle in which at least one was low. Never flags a falling edge.
// Assumes the history register starts at "both high" so reset gives no flag.
module odrep_release_det (
    input  logic clk,
    input  logic rst_n,
    input  logic a_high_i,
    input  logic b_high_i,
    output logic release_o
);

    logic both_high;
    logic both_high_q;

    assign both_high = a_high_i && b_high_i;

    // Remember last cycle's combined level.
    always_ff @(posedge clk) begin
        if (!rst_n) both_high_q <= 1'b1;
        else        both_high_q <= both_high;
    end

    assign release_o = both_high && !both_high_q;

endmodule

// File: rtl/odrep_accel_timer.sv
// Fixed-width pulse timer for one side's rise accelerator.
// A trigger loads PULSE_CYCLES; the output is high while the count is
// nonzero. enable_i low clears the count on the next edge.
// Assumes PULSE_CYCLES >= 1.
module odrep_accel_timer #(
    parameter int unsigned PULSE_CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic trigger_i,
    output logic active_o
);

    localparam int unsigned CNT_W = $clog2(PULSE_CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(PULSE_CYCLES);

    logic [CNT_W-1:0] cnt_q;

    // Load, count down, or clear.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (!enable_i)      cnt_q <= '0;
        else if (trigger_i)      cnt_q <= LOAD_VAL;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign active_o = (cnt_q != '0);

endmodule

// File: rtl/odrep_channel.sv
// One wire of a bidirectional open-drain repeater (top).
// Combines the direction latch, the release detector and one accelerator
// timer per side. Pull enables are removed combinationally on disconnect.
// Assumes level inputs are already synchronised; ACCEL_CYCLES >= 1.
module odrep_channel
    import odrep_pkg::*;
#(
    parameter int unsigned ACCEL_CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic connect_i,
    input  logic accel_en_i,
    input  logic a_level_i,
    input  logic b_level_i,
    output logic a_pull_o,
    output logic b_pull_o,
    output logic a_boost_o,
    output logic b_boost_o
);

    localparam int unsigned N_SIDES = 2;

    dir_e               dir;
    logic               release_evt;
    logic               boost_en;
    logic [N_SIDES-1:0] boost;

    odrep_dir_ctrl u_dir (
        .clk       (clk),
        .rst_n     (rst_n),
        .connect_i (connect_i),
        .a_high_i  (a_level_i),
        .b_high_i  (b_level_i),
        .dir_o     (dir)
    );

    odrep_release_det u_rel (
        .clk       (clk),
        .rst_n     (rst_n),
        .a_high_i  (a_level_i),
        .b_high_i  (b_level_i),
        .release_o (release_evt)
    );

    assign boost_en = connect_i && accel_en_i;

    // One accelerator timer per side.
    for (genvar s = 0; s < N_SIDES; s++) begin : g_side
        odrep_accel_timer #(
            .PULSE_CYCLES (ACCEL_CYCLES)
        ) u_timer (
            .clk       (clk),
            .rst_n     (rst_n),
            .enable_i  (boost_en),
            .trigger_i (release_evt),
            .active_o  (boost[s])
        );
    end

    // Follower side is pulled; nothing is pulled while disconnected.
    assign a_pull_o  = connect_i && (dir == DIR_B_LEADS);
    assign b_pull_o  = connect_i && (dir == DIR_A_LEADS);
    assign a_boost_o = boost[0];
    assign b_boost_o = boost[1];

endmodule

// File: rtl/odrep_channel_chk.sv
// Property checker for odrep_channel, attached by bind below.
// Assumes synchronous active-low reset; all properties disabled in reset.
module odrep_channel_chk (
    input logic clk,
    input logic rst_n,
    input logic connect_i,
    input logic accel_en_i,
    input logic a_level_i,
    input logic b_level_i,
    input logic a_pull_o,
    input logic b_pull_o,
    input logic a_boost_o,
    input logic b_boost_o
);

    p_no_mutual_pull_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_pull_o && b_pull_o));

    p_disc_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !connect_i |-> (!a_pull_o && !b_pull_o));

    p_disc_boost_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !connect_i |=> (!a_boost_o && !b_boost_o));

    p_boost_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !accel_en_i |=> (!a_boost_o && !b_boost_o));

    p_boost_sym_r7: assert property (@(posedge clk) disable iff (!rst_n)
        a_boost_o == b_boost_o);

    p_boost_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(a_boost_o) |-> $past(a_level_i && b_level_i));

    p_pull_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(b_pull_o) |-> $past(!a_level_i));

    p_pull_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(a_pull_o) |-> $past(!b_level_i));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (connect_i && b_pull_o && !a_level_i) |=> (b_pull_o || !connect_i));

    p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (connect_i && b_pull_o && a_level_i) |=> (!a_pull_o && !b_pull_o));

endmodule

bind odrep_channel odrep_channel_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .connect_i  (connect_i),
    .accel_en_i (accel_en_i),
    .a_level_i  (a_level_i),
    .b_level_i  (b_level_i),
    .a_pull_o   (a_pull_o),
    .b_pull_o   (b_pull_o),
    .a_boost_o  (a_boost_o),
    .b_boost_o  (b_boost_o)
);

// File: tb/odrep_channel_tb_top.sv
// Bench: closes the wired-AND loop (level = no external low and no pull)
// and compares the block cycle by cycle with a model built from R1..R10.
module odrep_channel_tb_top;

    localparam int P = 5;
    localparam time CLK_HALF = 10ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic conn = 1'b1;
    logic en = 1'b1;
    logic a_ext = 1'b0;
    logic b_ext = 1'b0;
    logic a_level, b_level, a_pull, b_pull, a_boost, b_boost;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // model state: 0 idle, 1 A leads, 2 B leads, 3 settle
    int m_dir = 0;
    int m_cnt = 0;
    bit m_bhq = 1'b1;

    always #(CLK_HALF) clk = ~clk;

    assign a_level = !(a_ext || a_pull);
    assign b_level = !(b_ext || b_pull);

    odrep_channel #(.ACCEL_CYCLES(P)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .connect_i  (conn),
        .accel_en_i (en),
        .a_level_i  (a_level),
        .b_level_i  (b_level),
        .a_pull_o   (a_pull),
        .b_pull_o   (b_pull),
        .a_boost_o  (a_boost),
        .b_boost_o  (b_boost)
    );

    function automatic bit exp_apull();
        return conn && (m_dir == 2);
    endfunction

    function automatic bit exp_bpull();
        return conn && (m_dir == 1);
    endfunction

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic cmp_all(input string tag);
        chk(tag, "a_pull", a_pull, exp_apull());
        chk(tag, "b_pull", b_pull, exp_bpull());
        chk(tag, "a_boost", a_boost, m_cnt != 0);
        chk(tag, "b_boost", b_boost, m_cnt != 0);
    endtask

    // Advance model over one edge, then compare after the edge.
    task automatic step(input string tag);
        bit ain, bin, bh;
        int nd;
        ain = !(a_ext || exp_apull());
        bin = !(b_ext || exp_bpull());
        bh  = ain && bin;
        nd  = m_dir;
        if (!conn) nd = 0;
        else case (m_dir)
            0: nd = !ain ? 1 : (!bin ? 2 : 0);
            1: nd = ain ? 3 : 1;
            2: nd = bin ? 3 : 2;
            default: nd = bh ? 0 : 3;
        endcase
        if (!conn || !en)    m_cnt = 0;
        else if (bh && !m_bhq) m_cnt = P;
        else if (m_cnt > 0)  m_cnt--;
        m_bhq = bh;
        m_dir = nd;
        @(posedge clk);
        #2;
        cmp_all(tag);
    endtask

    initial begin
        #(CLK_HALF * 2 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int cnt_hi;
        logic [15:0] lfsr;
        repeat (3) @(posedge clk);
        #2;
        // R1: reset state
        chk("R1", "a_pull", a_pull, 1'b0);
        chk("R1", "b_pull", b_pull, 1'b0);
        chk("R1", "a_boost", a_boost, 1'b0);
        chk("R1", "b_boost", b_boost, 1'b0);
        rst_n = 1'b1;
        step("R1");

        // R2 / R4: A leads, B's forced low ignored
        a_ext = 1'b1;
        step("R2");
        chk("R2", "b_pull hand", b_pull, 1'b1);
        for (int i = 0; i < 3; i++) begin
            step("R4");
            chk("R4", "a_pull hand", a_pull, 1'b0);
        end

        // R5: release
        a_ext = 1'b0;
        step("R5");
        chk("R5", "b_pull hand", b_pull, 1'b0);

        // R7: pulse length
        cnt_hi = 0;
        for (int i = 0; i < 3 * P; i++) begin
            step("R7");
            if (a_boost) cnt_hi++;
        end
        chk("R7", "pulse length ok", cnt_hi == P, 1'b1);

        // R3: B leads
        b_ext = 1'b1;
        step("R3");
        chk("R3", "a_pull hand", a_pull, 1'b1);
        step("R3");
        b_ext = 1'b0;
        for (int i = 0; i < 2 * P; i++) step("R3");

        // R6: tie
        a_ext = 1'b1;
        b_ext = 1'b1;
        step("R6");
        chk("R6", "b_pull hand", b_pull, 1'b1);
        chk("R6", "a_pull hand", a_pull, 1'b0);
        a_ext = 1'b0;
        step("R6");
        b_ext = 1'b0;
        for (int i = 0; i < 2 * P; i++) step("R6");

        // R8: no boost on falling edge or while low
        a_ext = 1'b1;
        for (int i = 0; i < 3; i++) begin
            step("R8");
            chk("R8", "a_boost hand", a_boost, 1'b0);
        end
        a_ext = 1'b0;
        for (int i = 0; i < 2 * P; i++) step("R8");

        // R9: accelerator off, repeating continues
        en = 1'b0;
        a_ext = 1'b1;
        step("R9");
        chk("R9", "b_pull hand", b_pull, 1'b1);
        a_ext = 1'b0;
        for (int i = 0; i < 2 * P; i++) begin
            step("R9");
            chk("R9", "b_boost hand", b_boost, 1'b0);
        end
        en = 1'b1;

        // R10: disconnect
        a_ext = 1'b1;
        step("R10");
        conn = 1'b0;
        #1;
        chk("R10", "b_pull comb", b_pull, 1'b0);
        chk("R10", "a_pull comb", a_pull, 1'b0);
        step("R10");
        b_ext = 1'b1;
        a_ext = 1'b0;
        step("R10");
        conn = 1'b1;
        step("R10");
        chk("R10", "a_pull fresh lead", a_pull, 1'b1);
        b_ext = 1'b0;
        for (int i = 0; i < 2 * P; i++) step("R10");

        // Sweep: pseudo-random drive in each connect/enable configuration
        lfsr = 16'hACE1;
        for (int cfg = 0; cfg < 5; cfg++) begin
            conn = (cfg != 0);
            en   = (cfg != 1);
            for (int i = 0; i < 600; i++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                if (lfsr[2:0] == 3'd0) a_ext = !a_ext;
                if (lfsr[5:3] == 3'd0) b_ext = !b_ext;
                if (cfg == 4) begin
                    if (lfsr[10:6] == 5'd0)  conn = !conn;
                    if (lfsr[15:11] == 5'd1) en = !en;
                end
                step(lfsr[0] ? "R3" : "R7");
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule